// File: doc/BRIEF.md
# Flash Page Erase/Program Controller

This block sits beside an on-chip flash array and performs whole-page erase and program operations for a processor. Software reaches it through a small register bank of 32-bit words, and it also sees every write the processor aims at the flash address range. A protective two-step key handshake has to come before any destructive operation. The order of the two key bytes decides the operation: 0x55 then 0xAA selects an erase, and 0xAA then 0x55 selects a program.

After the keys are accepted, the next write into the flash range acts as the trigger. The block clears the page-offset bits of that address and then streams over the whole page, one 32-bit word per clock. In erase mode it writes all-ones words. In program mode it writes words read from on-chip RAM, starting at the RAM location given by the buffer register. When the last word is written, a done flag and its interrupt are raised. A key mistake sets an error flag and drops the armed state. Both flags are cleared by writing ones to them.

The page is 512 bytes when control bits [31:3] are all zero, and 256 bytes otherwise. While a page operation runs, the block holds off all register writes and flash-range writes through two ready outputs. A held request completes once the page is finished.

Top module: `flash_page_ctl`

## Requirements
- R1: After reset, status reads 0, control reads 0, the buffer register reads 0x000C3E00, irq is 0, busy is 0 and both ready outputs are 1.
- R2: Writing 0x55 to the first key register (offset 0x04) and then 0xAA to the second key register (offset 0x08) arms an erase. The next flash-range write produces one flash word write per clock of 0xFFFFFFFF, at ascending word addresses from the page base.
- R3: Writing 0xAA to the first key and then 0x55 to the second arms a program. The trigger copies consecutive RAM words to ascending flash words. The first RAM word address is (buffer[23:0] − 0xC0000) >> 2, and RAM returns data one clock after the read strobe.
- R4: A first-key value other than 0x55 or 0xAA sets status bit 1 and leaves the block unarmed. A following second key does not arm it, and a following flash-range write starts nothing.
- R5: A second key that does not complete an armed first key (for example 0x55 then 0x55) sets status bit 1 and leaves the block unarmed.
- R6: When control bits [31:3] are zero, a page is 128 words on a 512-byte boundary. Otherwise it is 64 words on a 256-byte boundary. In both cases the page is the one holding the trigger address.
- R7: Busy is high from the clock after the trigger is accepted until the last flash write. Counting from that first cycle, it stays high for page-words + 1 cycles. Status bit 0 is set the clock after the last flash write, and irq equals status bit 0 (offset 0x0C, bits [1:0]).
- R8: A write to the status register clears each of bits [1:0] written as 1 and leaves bits written as 0 unchanged.
- R9: A flash-range write while the block is not armed is ignored. It causes no flash write, no busy and no status change, and this includes a second write after an operation has completed.
- R10: While busy, reg_ready and fw_ready are low. A request held across the busy period is accepted after the page completes and takes its normal effect.
- R11: A register write that arrives in the same cycle as a flash-range write is held (reg_ready low) while the flash-range write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write request, held until reg_ready |
| reg_addr | input | 5 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| reg_ready | output | 1 | Register write accepted this cycle when high |
| fw_valid | input | 1 | Write aimed at the flash range, held until fw_ready |
| fw_addr | input | FLASH_AW | Byte address of that flash-range write |
| fw_ready | output | 1 | Flash-range write accepted this cycle when high |
| fl_we | output | 1 | Flash word write strobe |
| fl_waddr | output | FLASH_AW-2 | Flash word address |
| fl_wdata | output | 32 | Flash word write data |
| ram_re | output | 1 | RAM read strobe |
| ram_raddr | output | RAM_AW-2 | RAM word address |
| ram_rdata | input | 32 | RAM read data, valid one clock after ram_re |
| busy | output | 1 | Page operation in progress |
| irq | output | 1 | Done interrupt, mirrors status bit 0 |

## Verification
The bench targets four kinds of corner case. The first is key-order mistakes: a bad first key, or a repeated key byte. A design that checked only the second key would arm anyway and then erase a page it should not touch. The second is the page boundary for both page sizes, using trigger addresses in the middle and at the top of the range. A wrong mask would start the stream off a page boundary, or cover half or double a page. The third is the one-clock RAM latency during program. An off-by-one pipeline would shift every flash word by one RAM location. The last is requests held across the busy window and requests arriving together, where a design that dropped or reordered them would lose a key write or corrupt the armed state.

// File: rtl/flash_page_ctl.sv
module flash_page_ctl #(
  parameter int          FLASH_AW = 19,
  parameter int          RAM_AW   = 14,
  parameter logic [31:0] RAM_BASE = 32'h000C_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [4:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 reg_ready,
  input  logic                 fw_valid,
  input  logic [FLASH_AW-1:0]  fw_addr,
  output logic                 fw_ready,
  output logic                 fl_we,
  output logic [FLASH_AW-3:0]  fl_waddr,
  output logic [31:0]          fl_wdata,
  output logic                 ram_re,
  output logic [RAM_AW-3:0]    ram_raddr,
  input  logic [31:0]          ram_rdata,
  output logic                 busy,
  output logic                 irq
);
  localparam int FWA       = FLASH_AW - 2;
  localparam int RWA       = RAM_AW - 2;
  localparam int BIG_WORDS = 512 / 4;
  localparam int SML_WORDS = 256 / 4;
  localparam int CW        = $clog2(BIG_WORDS);
  localparam logic [31:0] BUF_RST = RAM_BASE + (32'd1 << RAM_AW) - 32'd512;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_KEY1 = 5'h04;
  localparam logic [4:0] A_KEY2 = 5'h08;
  localparam logic [4:0] A_STAT = 5'h0C;
  localparam logic [4:0] A_BUF  = 5'h10;

  typedef enum logic [2:0] {S_IDLE, S_K55, S_KAA, S_ERASE, S_PROG} seq_t;

  seq_t        seq_q;
  logic [31:0] ctrl_q, key1_q, key2_q, buf_q;
  logic [1:0]  st_q;
  logic        run_q, wr_v_q, prog_q, small_q;
  logic [CW-1:0]  cnt_q;
  logic [FWA-1:0] pbase_q, wa_q;
  logic [RWA-1:0] rbase_q;

  assign busy      = run_q | wr_v_q;
  assign fw_ready  = !busy;
  assign reg_ready = !busy && !fw_valid;
  assign irq       = st_q[0];

  wire wr_acc = reg_wr && reg_ready;
  wire fw_acc = fw_valid && fw_ready;
  wire trig   = fw_acc && (seq_q == S_ERASE || seq_q == S_PROG);

  wire            small_pg  = |ctrl_q[31:3];
  wire [FWA-1:0]  pg_mask   = small_pg ? ~FWA'(SML_WORDS - 1) : ~FWA'(BIG_WORDS - 1);
  wire [FWA-1:0]  trig_base = fw_addr[FLASH_AW-1:2] & pg_mask;
  wire [23:0]     rel_off   = buf_q[23:0] - RAM_BASE[23:0];
  wire [CW-1:0]   last_cnt  = small_q ? CW'(SML_WORDS - 1) : CW'(BIG_WORDS - 1);
  wire            key2_ok   = (seq_q == S_K55 && reg_wdata == 32'hAA) ||
                              (seq_q == S_KAA && reg_wdata == 32'h55);

  assign ram_re    = run_q && prog_q;
  assign ram_raddr = rbase_q + RWA'(cnt_q);
  assign fl_we     = wr_v_q;
  assign fl_waddr  = wa_q;
  assign fl_wdata  = prog_q ? ram_rdata : 32'hFFFF_FFFF;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_KEY1:  reg_rdata = key1_q;
      A_KEY2:  reg_rdata = key2_q;
      A_STAT:  reg_rdata = {30'd0, st_q};
      A_BUF:   reg_rdata = buf_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q   <= S_IDLE;
      ctrl_q  <= '0;
      key1_q  <= '0;
      key2_q  <= '0;
      buf_q   <= BUF_RST;
      st_q    <= '0;
      run_q   <= 1'b0;
      wr_v_q  <= 1'b0;
      prog_q  <= 1'b0;
      small_q <= 1'b0;
      cnt_q   <= '0;
      pbase_q <= '0;
      wa_q    <= '0;
      rbase_q <= '0;
    end else begin
      wr_v_q <= run_q;
      if (run_q) begin
        wa_q  <= pbase_q + FWA'(cnt_q);
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == last_cnt) run_q <= 1'b0;
      end
      if (wr_v_q && !run_q) st_q[0] <= 1'b1;

      if (trig) begin
        run_q   <= 1'b1;
        cnt_q   <= '0;
        prog_q  <= (seq_q == S_PROG);
        small_q <= small_pg;
        pbase_q <= trig_base;
        rbase_q <= rel_off[RAM_AW-1:2];
        seq_q   <= S_IDLE;
      end

      if (wr_acc) begin
        case (reg_addr)
          A_CTRL: ctrl_q <= reg_wdata;
          A_BUF:  buf_q  <= reg_wdata;
          A_STAT: st_q   <= st_q & ~reg_wdata[1:0];
          A_KEY1: begin
            key1_q <= reg_wdata;
            if (reg_wdata == 32'h55)      seq_q <= S_K55;
            else if (reg_wdata == 32'hAA) seq_q <= S_KAA;
            else begin
              seq_q   <= S_IDLE;
              st_q[1] <= 1'b1;
            end
          end
          A_KEY2: begin
            key2_q <= reg_wdata;
            if (key2_ok) seq_q <= (seq_q == S_K55) ? S_ERASE : S_PROG;
            else begin
              seq_q   <= S_IDLE;
              st_q[1] <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R4: an invalid first key raises the error flag
  a_r4_bad_key1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && reg_addr == A_KEY1 && reg_wdata != 32'h55 && reg_wdata != 32'hAA |=> st_q[1]);

  // R5: a second key that does not complete the first raises the error flag
  a_r5_bad_key2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && reg_addr == A_KEY2 && !key2_ok |=> st_q[1] && !busy);

  // R2: flash words of one page are written at ascending addresses
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we && $past(fl_we) |-> fl_waddr == $past(fl_waddr) + 1'b1);

  // R7: done is flagged as the page stream ends
  a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

  // R8: writing one to status bit 0 drops the interrupt
  a_r8_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc && reg_addr == A_STAT && reg_wdata[0] |=> !irq);

  // R9: an unarmed flash-range write starts nothing
  a_r9_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    fw_acc && seq_q == S_IDLE |=> !busy && $stable(st_q));
endmodule

// File: tb/flash_page_ctl_test.sv
`timescale 1ns/1ps
module flash_page_ctl_test;
  localparam int FLASH_AW = 19;
  localparam int RAM_AW   = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic reg_ready;
  logic fw_valid = 1'b0;
  logic [FLASH_AW-1:0] fw_addr = '0;
  logic fw_ready;
  logic fl_we;
  logic [FLASH_AW-3:0] fl_waddr;
  logic [31:0] fl_wdata;
  logic ram_re;
  logic [RAM_AW-3:0] ram_raddr;
  logic [31:0] ram_rdata = '0;
  logic busy, irq;

  always #4 clk = ~clk;

  flash_page_ctl #(.FLASH_AW(FLASH_AW), .RAM_AW(RAM_AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_ready(reg_ready),
    .fw_valid(fw_valid), .fw_addr(fw_addr), .fw_ready(fw_ready),
    .fl_we(fl_we), .fl_waddr(fl_waddr), .fl_wdata(fl_wdata),
    .ram_re(ram_re), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .busy(busy), .irq(irq));

  function automatic logic [31:0] pat(input logic [RAM_AW-3:0] a);
    return {16'hC0DE, 4'h0, a};
  endfunction

  always @(posedge clk) if (ram_re) ram_rdata <= pat(ram_raddr);

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_data_q[$];
  string cur_req = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && fl_we) begin
      if (exp_addr_q.size() == 0) begin
        check(1'b0, "R9", "unexpected flash write", {13'd0, fl_waddr}, 32'hFFFF_FFFF);
      end else begin
        logic [31:0] ea, ed;
        ea = exp_addr_q.pop_front();
        ed = exp_data_q.pop_front();
        check({13'd0, fl_waddr} == ea, cur_req, "flash word address", {13'd0, fl_waddr}, ea);
        check(fl_wdata == ed, cur_req, "flash word data", fl_wdata, ed);
      end
    end
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    while (!reg_ready) @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic win_write(input logic [FLASH_AW-1:0] a);
    @(negedge clk);
    fw_valid = 1'b1; fw_addr = a;
    while (!fw_ready) @(negedge clk);
    @(negedge clk);
    fw_valid = 1'b0;
  endtask

  task automatic push_erase(input int base, input int n);
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(32'(base + i));
      exp_data_q.push_back(32'hFFFF_FFFF);
    end
  endtask

  task automatic push_prog(input int base, input int rbase, input int n);
    for (int i = 0; i < n; i++) begin
      exp_addr_q.push_back(32'(base + i));
      exp_data_q.push_back(pat((RAM_AW-2)'(rbase + i)));
    end
  endtask

  task automatic wait_done(input int words, input string req);
    int n = 0;
    while (busy && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(n == words + 1, "R7", "busy cycles", 32'(n), 32'(words + 1));
    check(irq == 1'b1, "R7", "irq after done", {31'd0, irq}, 32'd1);
    check(exp_addr_q.size() == 0, req, "page words left", 32'(exp_addr_q.size()), 32'd0);
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
    if (!finished) begin
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(1);

    // R1 reset state
    reg_read(5'h0C, v); check(v == 32'd0, "R1", "status", v, 32'd0);
    reg_read(5'h00, v); check(v == 32'd0, "R1", "control", v, 32'd0);
    reg_read(5'h10, v); check(v == 32'h000C3E00, "R1", "buffer", v, 32'h000C3E00);
    check(irq == 1'b0 && busy == 1'b0, "R1", "irq/busy", {30'd0, irq, busy}, 32'd0);
    check(reg_ready && fw_ready, "R1", "readies", {30'd0, reg_ready, fw_ready}, 32'd3);

    // R9 unarmed flash-range write
    cur_req = "R9";
    win_write(19'h00400);
    idle_cycles(4);
    check(busy == 1'b0, "R9", "busy after idle write", {31'd0, busy}, 32'd0);
    reg_read(5'h0C, v); check(v == 32'd0, "R9", "status after idle write", v, 32'd0);

    // R2 + R6: erase, 512-byte page, mid-page trigger 0x1234 -> word base 0x480
    cur_req = "R2";
    reg_write(5'h04, 32'h55);
    reg_write(5'h08, 32'hAA);
    push_erase(32'h480, 128);
    win_write(19'h01234);
    wait_done(128, "R6");
    reg_read(5'h0C, v); check(v == 32'd1, "R7", "status done", v, 32'd1);

    // R8 write-one-to-clear
    reg_write(5'h0C, 32'h2);
    reg_read(5'h0C, v); check(v == 32'd1, "R8", "bit0 kept by zero", v, 32'd1);
    reg_write(5'h0C, 32'h1);
    reg_read(5'h0C, v); check(v == 32'd0, "R8", "bit0 cleared", v, 32'd0);
    check(irq == 1'b0, "R8", "irq cleared", {31'd0, irq}, 32'd0);

    // R9 second write after completed operation
    cur_req = "R9";
    win_write(19'h01234);
    idle_cycles(4);
    check(busy == 1'b0, "R9", "no rerun", {31'd0, busy}, 32'd0);

    // R3 + R6: program, 256-byte page at top of range
    cur_req = "R3";
    reg_write(5'h00, 32'h8);
    reg_write(5'h10, 32'h000C1000);
    reg_write(5'h04, 32'hAA);
    reg_write(5'h08, 32'h55);
    push_prog(32'h1FFC0, 32'h400, 64);
    win_write(19'h7FFFC);
    wait_done(64, "R6");
    reg_write(5'h0C, 32'h3);

    // R4 bad first key
    cur_req = "R4";
    reg_write(5'h04, 32'h12);
    reg_read(5'h0C, v); check(v == 32'd2, "R4", "error flag", v, 32'd2);
    reg_write(5'h0C, 32'h2);
    reg_write(5'h08, 32'hAA);
    win_write(19'h00000);
    idle_cycles(4);
    check(busy == 1'b0, "R4", "not armed", {31'd0, busy}, 32'd0);
    reg_read(5'h0C, v); check(v == 32'd2, "R4", "second key also rejected", v, 32'd2);
    reg_write(5'h0C, 32'h2);

    // R5 repeated key byte
    cur_req = "R5";
    reg_write(5'h04, 32'h55);
    reg_write(5'h08, 32'h55);
    reg_read(5'h0C, v); check(v == 32'd2, "R5", "error flag", v, 32'd2);
    win_write(19'h00000);
    idle_cycles(4);
    check(busy == 1'b0, "R5", "not armed", {31'd0, busy}, 32'd0);
    reg_write(5'h0C, 32'h2);

    // R10 held request across busy, 512-byte pages
    cur_req = "R10";
    reg_write(5'h00, 32'h0);
    reg_write(5'h04, 32'h55);
    reg_write(5'h08, 32'hAA);
    push_erase(32'h80, 128);
    win_write(19'h00200);
    check(!reg_ready && !fw_ready, "R10", "readies low while busy",
          {30'd0, reg_ready, fw_ready}, 32'd0);
    reg_write(5'h04, 32'hAA);
    check(exp_addr_q.size() == 0, "R10", "erase finished before key", 32'(exp_addr_q.size()), 32'd0);
    reg_read(5'h0C, v); check(v == 32'd1, "R10", "held key accepted without error", v, 32'd1);
    reg_write(5'h08, 32'h55);
    push_prog(32'h0, 32'h400, 128);
    win_write(19'h00010);
    wait_done(128, "R10");
    reg_write(5'h0C, 32'h3);

    // R11 simultaneous register and flash-range writes
    @(negedge clk);
    fw_valid = 1'b1; fw_addr = 19'h00100;
    reg_wr = 1'b1; reg_addr = 5'h10; reg_wdata = 32'h000C2000;
    #1;
    check(!reg_ready && fw_ready, "R11", "register write held",
          {30'd0, reg_ready, fw_ready}, 32'd1);
    @(negedge clk);
    fw_valid = 1'b0;
    @(negedge clk);
    #1 check(reg_ready == 1'b1, "R11", "register write released", {31'd0, reg_ready}, 32'd1);
    @(negedge clk);
    reg_wr = 1'b0;
    reg_read(5'h10, v); check(v == 32'h000C2000, "R11", "held write landed", v, 32'h000C2000);

    idle_cycles(4);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule